// File: doc/BRIEF.md
# Register-Form Move and Shift Execute Unit

This unit takes one 32-bit data-processing instruction word of the register-operand move/shift group, decides whether the word is a legal member of that group, and computes the value to write back. The instruction's source register value and the current carry flag come from outside. The unit runs a single barrel shifter with a shift kind and an amount that it decodes from the word. From the result it derives the destination write and the condition-flag updates.

One opcode covers six operations. The 2-bit type field and the 5-bit immediate together select a plain copy, a logical left shift, a logical right shift, an arithmetic right shift, a rotate right, or a one-bit rotate through the carry. The condition field is not evaluated here. The register file, program-counter branching and the other operand forms belong to other blocks.

The decode and shift logic is combinational. It feeds one register stage, which raises `res_valid` one clock after `op_valid`. A caller applies the word and the operands, and reads the write-back and flag updates on the next cycle.

Top module: `mvsh_exec`

## Requirements
- R1: A word is a group member only if bits[27:25]=000, bits[24:21]=1101, bits[19:16]=0000 and bit4=0. Bits[31:28] are ignored. Any other word gives `res_legal`=0 and raises no write enable.
- R2: A member word whose source index, bits[3:0], equals 15 is illegal.
- R3: A member word with destination index bits[15:12]=15 and bit20 (set-flags) = 1 is illegal. With bit20 = 0 the same destination is legal.
- R4: Type bits[6:5]=0 with imm5 bits[11:7]=0 copies the source unchanged and never writes the carry.
- R5: Type 0 with imm5=n (1..31) shifts left by n. The carry-out is source bit 32-n.
- R6: Type 1 shifts logically right by imm5, where imm5=0 means 32. The carry-out is source bit n-1.
- R7: Type 2 shifts arithmetically right by imm5, where imm5=0 means 32. The result is filled with the sign bit, and the carry-out is source bit n-1.
- R8: Type 3 with imm5=n≠0 rotates right by n. The carry-out is result bit 31.
- R9: Type 3 with imm5=0 shifts right by one and inserts `c_in` at bit 31. The carry-out is source bit 0.
- R10: For a legal word with bit20=1, N is written with result bit 31 and Z with (result==0). With bit20=0 no flag enable is raised.
- R11: The carry enable is raised only for a legal word with bit20=1 that performs a shift, which is every case except R4. The carry value then equals the shifter carry-out.
- R12: Every legal word raises `rd_we`, with `rd_idx` = bits[15:12] and `rd_data` = the shift result.
- R13: Outputs are registered. `res_valid` follows `op_valid` by one clock, and all outputs are zero during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction word and operands are present |
| op_word | input | 32 | Instruction word |
| src_val | input | 32 | Value of the source register |
| c_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Registered result is present |
| res_legal | output | 1 | Word was a legal member of the group |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | 32 | Destination write data |
| n_we | output | 1 | Negative flag write enable |
| n_next | output | 1 | New negative flag |
| z_we | output | 1 | Zero flag write enable |
| z_next | output | 1 | New zero flag |
| c_we | output | 1 | Carry flag write enable |
| c_next | output | 1 | New carry flag |

## Verification
A wrong decoded shift kind or amount shows up in `rd_data` and `c_next` in the next clock, for the same word. A broken legality check appears at once as `rd_we` or a flag enable that should not be raised. The special imm5=0 cases need their own stimulus, because a default amount of zero instead of 32 looks correct for most other words. These cases are right shifts that mean 32, the copy that must leave the carry alone, and the rotate-through-carry.

// File: rtl/mvsh_pkg.sv
// Package: shared widths, shift kinds and the decoded-instruction record
// for the move/shift execute unit. Assumes a 32-bit instruction word.
package mvsh_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 4;

    // Kind of operation the shifter performs
    typedef enum logic [2:0] {
        SK_COPY = 3'd0,
        SK_LSL  = 3'd1,
        SK_LSR  = 3'd2,
        SK_ASR  = 3'd3,
        SK_ROR  = 3'd4,
        SK_RRX  = 3'd5
    } shift_kind_e;

    // Decoded fields of one word
    typedef struct packed {
        logic              member;
        logic              legal;
        logic              set_flags;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rm;
        shift_kind_e       kind;
        logic [4:0]        imm5;
    } decoded_t;

endpackage

// File: rtl/mvsh_decode.sv
// Module: mvsh_decode
// Purpose: pattern-matches the register-form move/shift word, checks the
// illegal register combinations and picks the shift kind and amount.
// Assumes: the condition field is handled elsewhere; combinational only.
module mvsh_decode
    import mvsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W) + 1
) (
    input  logic [27:0]      word_lo,
    output decoded_t         dec,
    output logic [AMT_W-1:0] amount
);

    localparam logic [REG_W-1:0] PC_IDX  = '1;
    localparam logic [3:0]       OPC_MOV = 4'b1101;
    localparam logic [AMT_W-1:0] FULL    = AMT_W'(DATA_W);

    logic [1:0] typ;
    logic       zero_imm;

    // Field extraction and legality
    always_comb begin
        typ           = word_lo[6:5];
        dec.imm5      = word_lo[11:7];
        dec.rd        = word_lo[15:12];
        dec.rm        = word_lo[3:0];
        dec.set_flags = word_lo[20];
        dec.member    = (word_lo[27:25] == 3'b000) && (word_lo[24:21] == OPC_MOV)
                     && (word_lo[19:16] == 4'b0000) && !word_lo[4];
        dec.legal     = dec.member && (dec.rm != PC_IDX)
                     && !((dec.rd == PC_IDX) && dec.set_flags);
        zero_imm      = (dec.imm5 == 5'd0);
    end

    // Shift kind and amount from type and imm5
    always_comb begin
        dec.kind = SK_COPY;
        amount   = AMT_W'(dec.imm5);
        unique case (typ)
            2'd0: dec.kind = zero_imm ? SK_COPY : SK_LSL;
            2'd1: begin
                dec.kind = SK_LSR;
                if (zero_imm) amount = FULL;
            end
            2'd2: begin
                dec.kind = SK_ASR;
                if (zero_imm) amount = FULL;
            end
            default: begin
                dec.kind = zero_imm ? SK_RRX : SK_ROR;
                if (zero_imm) amount = AMT_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/mvsh_shifter.sv
// Module: mvsh_shifter
// Purpose: barrel shifter producing result and carry-out for the six kinds.
// Assumes: DATA_W is a power of two; LSL/ROR amounts 1..DATA_W-1,
// LSR/ASR amounts 1..DATA_W; COPY passes value and carry through.
module mvsh_shifter
    import mvsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W) + 1,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amount,
    input  logic [DATA_W-1:0] value,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    logic [DATA_W:0]        left_ext;
    logic [DATA_W:0]        right_ext;
    logic signed [DATA_W:0] arith_ext;
    logic [DATA_W-1:0]      rot_stage [LOG_W+1];

    // Extended shifts that capture the last bit shifted out
    always_comb begin
        left_ext  = {1'b0, value} << amount;
        right_ext = {value, 1'b0} >> amount;
        arith_ext = $signed({value, 1'b0}) >>> amount;
    end

    // Logarithmic rotate network, one stage per amount bit
    assign rot_stage[0] = value;
    for (genvar k = 0; k < LOG_W; k++) begin : g_rot
        localparam int STEP = 1 << k;
        assign rot_stage[k+1] = amount[k]
            ? {rot_stage[k][STEP-1:0], rot_stage[k][DATA_W-1:STEP]}
            : rot_stage[k];
    end

    // Output selection by kind
    always_comb begin
        result    = value;
        carry_out = carry_in;
        unique case (kind)
            SK_LSL: begin
                result    = left_ext[DATA_W-1:0];
                carry_out = left_ext[DATA_W];
            end
            SK_LSR: begin
                result    = right_ext[DATA_W:1];
                carry_out = right_ext[0];
            end
            SK_ASR: begin
                result    = arith_ext[DATA_W:1];
                carry_out = arith_ext[0];
            end
            SK_ROR: begin
                result    = rot_stage[LOG_W];
                carry_out = rot_stage[LOG_W][DATA_W-1];
            end
            SK_RRX: begin
                result    = {carry_in, value[DATA_W-1:1]};
                carry_out = value[0];
            end
            default: begin
                result    = value;
                carry_out = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/mvsh_flags.sv
// Module: mvsh_flags
// Purpose: derives N/Z/C next values and their write enables.
// Assumes: overflow is never touched by this group; combinational only.
module mvsh_flags #(
    parameter int DATA_W = 32
) (
    input  logic              legal,
    input  logic              set_flags,
    input  logic              shifted,
    input  logic [DATA_W-1:0] result,
    input  logic              shift_carry,
    output logic              n_we,
    output logic              n_val,
    output logic              z_we,
    output logic              z_val,
    output logic              c_we,
    output logic              c_val
);

    // Flag values and enables
    always_comb begin
        n_val = result[DATA_W-1];
        z_val = (result == '0);
        c_val = shift_carry;
        n_we  = legal && set_flags;
        z_we  = legal && set_flags;
        c_we  = legal && set_flags && shifted;
    end

endmodule

// File: rtl/mvsh_exec.sv
// Module: mvsh_exec (top)
// Purpose: register-form move/shift execute: decode, shift, flag update,
// then one output register stage with a valid strobe.
// Assumes: synchronous active-low reset; the caller applies one word per
// cycle with op_valid, and the results appear one clock later.
module mvsh_exec
    import mvsh_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [31:0]       op_word,
    input  logic [DATA_W-1:0] src_val,
    input  logic              c_in,
    output logic              res_valid,
    output logic              res_legal,
    output logic              rd_we,
    output logic [REG_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              n_we,
    output logic              n_next,
    output logic              z_we,
    output logic              z_next,
    output logic              c_we,
    output logic              c_next
);

    decoded_t          dec;
    logic [AMT_W-1:0]  amount;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic              f_nwe, f_nval, f_zwe, f_zval, f_cwe, f_cval;
    logic              unused_cond;

    assign unused_cond = ^op_word[31:28];

    mvsh_decode #(.DATA_W(DATA_W)) u_dec (
        .word_lo (op_word[27:0]),
        .dec     (dec),
        .amount  (amount)
    );

    mvsh_shifter #(.DATA_W(DATA_W)) u_shf (
        .kind      (dec.kind),
        .amount    (amount),
        .value     (src_val),
        .carry_in  (c_in),
        .result    (sh_res),
        .carry_out (sh_carry)
    );

    mvsh_flags #(.DATA_W(DATA_W)) u_flg (
        .legal       (dec.legal),
        .set_flags   (dec.set_flags),
        .shifted     (dec.kind != SK_COPY),
        .result      (sh_res),
        .shift_carry (sh_carry),
        .n_we        (f_nwe),
        .n_val       (f_nval),
        .z_we        (f_zwe),
        .z_val       (f_zval),
        .c_we        (f_cwe),
        .c_val       (f_cval)
    );

    // Output register stage, enables gated by op_valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_legal <= 1'b0;
            rd_we     <= 1'b0;
            rd_idx    <= '0;
            rd_data   <= '0;
            n_we      <= 1'b0;
            n_next    <= 1'b0;
            z_we      <= 1'b0;
            z_next    <= 1'b0;
            c_we      <= 1'b0;
            c_next    <= 1'b0;
        end else begin
            res_valid <= op_valid;
            res_legal <= op_valid && dec.legal;
            rd_we     <= op_valid && dec.legal;
            rd_idx    <= dec.rd;
            rd_data   <= sh_res;
            n_we      <= op_valid && f_nwe;
            n_next    <= f_nval;
            z_we      <= op_valid && f_zwe;
            z_next    <= f_zval;
            c_we      <= op_valid && f_cwe;
            c_next    <= f_cval;
        end
    end

    // R13: valid strobe follows the input strobe by one clock
    p_valid_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R2: a source index of 15 never produces a legal result
    p_rm_pc_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[3:0] == 4'hF) |=> (!res_legal && !rd_we));

    // R1: no enable is raised for an illegal or absent result
    p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_legal |-> (!rd_we && !n_we && !z_we && !c_we));

    // R11: carry is written only together with N and Z
    p_carry_with_nz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> (n_we && z_we));

    // R4: a plain copy passes the source value and leaves carry alone
    p_copy_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dec.legal && op_word[11:5] == 7'd0)
        |=> (rd_data == $past(src_val) && !c_we));

    // R10: zero flag agrees with the written data
    p_zero_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        z_we |-> (z_next == (rd_data == '0)));

endmodule

// File: tb/mvsh_exec_tb.sv
module mvsh_exec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [31:0] op_word;
    logic [31:0] src_val;
    logic        c_in;
    logic        res_valid, res_legal, rd_we, n_we, n_next, z_we, z_next, c_we, c_next;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    // expected outputs for the word applied at the previous negedge
    logic        e_valid, e_legal, e_rdwe, e_nwe, e_zwe, e_cwe, e_n, e_z, e_c;
    logic [3:0]  e_idx;
    logic [31:0] e_data;
    string       e_tag, e_ltag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mvsh_exec u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .src_val(src_val), .c_in(c_in), .res_valid(res_valid),
        .res_legal(res_legal), .rd_we(rd_we), .rd_idx(rd_idx),
        .rd_data(rd_data), .n_we(n_we), .n_next(n_next), .z_we(z_we),
        .z_next(z_next), .c_we(c_we), .c_next(c_next)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit s, input int rd, input int imm,
                                       input int typ, input int rm);
        return {4'hE, 3'b000, 4'b1101, s, 4'b0000, 4'(rd), 5'(imm), 2'(typ), 1'b0, 4'(rm)};
    endfunction

    // Behavioural reference for one applied word
    task automatic model(input logic v, input logic [31:0] w, input logic [31:0] x0,
                         input logic c0);
        logic [31:0] x;
        logic        car, shifted, member, legal, s;
        int          n;
        x = x0; car = c0; shifted = 1;
        s = w[20];
        member = (w[27:25] == 3'b000) && (w[24:21] == 4'hD) && (w[19:16] == 4'h0) && !w[4];
        legal  = member && (w[3:0] != 4'hF) && !((w[15:12] == 4'hF) && s);
        n = int'(w[11:7]);
        case (w[6:5])
            2'd0: if (n == 0) begin shifted = 0; e_tag = "R4"; end
                  else begin
                      e_tag = "R5";
                      for (int i = 0; i < n; i++) begin car = x[31]; x = x << 1; end
                  end
            2'd1: begin
                e_tag = "R6"; if (n == 0) n = 32;
                for (int i = 0; i < n; i++) begin car = x[0]; x = x >> 1; end
            end
            2'd2: begin
                e_tag = "R7"; if (n == 0) n = 32;
                for (int i = 0; i < n; i++) begin car = x[0]; x = {x[31], x[31:1]}; end
            end
            default: if (n != 0) begin
                e_tag = "R8";
                for (int i = 0; i < n; i++) x = {x[0], x[31:1]};
                car = x[31];
            end else begin
                e_tag = "R9"; car = x[0]; x = {c0, x[31:1]};
            end
        endcase
        e_ltag  = !member ? "R1" : (w[3:0] == 4'hF) ? "R2" : (w[15:12] == 4'hF) ? "R3" : "R1";
        e_valid = v;
        e_legal = v && legal;
        e_rdwe  = v && legal;
        e_idx   = w[15:12];
        e_data  = x;
        e_nwe   = v && legal && s;
        e_zwe   = v && legal && s;
        e_cwe   = v && legal && s && shifted;
        e_n     = x[31];
        e_z     = (x == 0);
        e_c     = car;
    endtask

    task automatic compare();
        chk(res_valid == e_valid, "R13", "res_valid", 32'(res_valid), 32'(e_valid));
        chk(res_legal == e_legal, e_ltag, "res_legal", 32'(res_legal), 32'(e_legal));
        chk(rd_we == e_rdwe, "R12", "rd_we", 32'(rd_we), 32'(e_rdwe));
        if (e_rdwe) begin
            chk(rd_idx == e_idx, "R12", "rd_idx", 32'(rd_idx), 32'(e_idx));
            chk(rd_data == e_data, e_tag, "rd_data", rd_data, e_data);
        end
        chk(n_we == e_nwe && z_we == e_zwe, "R10", "n_we/z_we",
            {30'd0, n_we, z_we}, {30'd0, e_nwe, e_zwe});
        if (e_nwe)
            chk(n_next == e_n && z_next == e_z, "R10", "n/z",
                {30'd0, n_next, z_next}, {30'd0, e_n, e_z});
        chk(c_we == e_cwe, "R11", "c_we", 32'(c_we), 32'(e_cwe));
        if (e_cwe) chk(c_next == e_c, e_tag, "c_next", 32'(c_next), 32'(e_c));
    endtask

    // One clock: check previous result, then apply a new word
    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] x,
                        input logic c);
        @(negedge clk);
        compare();
        op_valid = v; op_word = w; src_val = x; c_in = c;
        model(v, w, x, c);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_word = '0; src_val = '0; c_in = 1'b0;
        model(1'b0, 32'h0, 32'h0, 1'b0);
        e_tag = "R13"; e_ltag = "R13";
        repeat (3) @(negedge clk);
        // R13: reset state
        compare();
        @(negedge clk); rst_n = 1'b1;

        step(1, mk(1, 2, 0, 0, 3), 32'h8000_0001, 1);   // R4 copy, S set
        step(1, mk(1, 2, 0, 0, 3), 32'h0000_0000, 0);   // R4 copy, Z set
        step(1, mk(1, 4, 1, 0, 5), 32'hC000_0001, 0);   // R5 LSL 1
        step(1, mk(1, 4, 31, 0, 5), 32'h0000_0003, 0);  // R5 LSL 31
        step(1, mk(1, 6, 0, 1, 7), 32'h8000_0000, 0);   // R6 LSR 32
        step(1, mk(1, 6, 1, 1, 7), 32'h0000_0003, 0);   // R6 LSR 1
        step(1, mk(1, 6, 0, 2, 7), 32'h8000_1234, 0);   // R7 ASR 32 negative
        step(1, mk(1, 6, 0, 2, 7), 32'h7000_1234, 1);   // R7 ASR 32 positive
        step(1, mk(1, 6, 4, 2, 7), 32'h8000_00F8, 1);   // R7 ASR 4
        step(1, mk(1, 8, 4, 3, 9), 32'h1234_5678, 0);   // R8 ROR 4
        step(1, mk(1, 8, 0, 3, 9), 32'h0000_0001, 1);   // R9 RRX carry 1
        step(1, mk(1, 8, 0, 3, 9), 32'h0000_0002, 0);   // R9 RRX carry 0
        step(1, mk(0, 8, 3, 1, 9), 32'hFFFF_FFFF, 0);   // R10 no flags when S clear
        step(1, mk(1, 1, 3, 1, 15), 32'h1111_1111, 0);  // R2 source is PC
        step(1, mk(1, 15, 3, 1, 1), 32'h1111_1111, 0);  // R3 dest PC with S
        step(0, mk(1, 3, 3, 1, 1), 32'h1111_1111, 0);   // R13 idle cycle
        step(1, mk(0, 15, 3, 1, 1), 32'h1111_1111, 0);  // R3 dest PC without S
        step(1, mk(1, 2, 0, 0, 3) | 32'h10, 32'h5, 0);  // R1 bit4 set
        step(1, mk(1, 2, 0, 0, 3) ^ 32'h0020_0000, 32'h5, 0); // R1 opcode change
        step(1, mk(1, 2, 0, 0, 3) | 32'h0001_0000, 32'h5, 0); // R1 bits19:16
        step(1, mk(1, 2, 0, 0, 3) | 32'h0200_0000, 32'h5, 0); // R1 bits27:25
        step(1, (mk(1, 2, 0, 0, 3) & 32'h0FFF_FFFF), 32'h5, 1); // R1 cond ignored

        // Mixed patterns, mostly legal, all types and amounts
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            w = mk($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 31),
                   $urandom_range(0, 3), $urandom_range(0, 15));
            if ($urandom_range(0, 9) == 0) w = w ^ (32'h1 << $urandom_range(4, 27));
            step($urandom_range(0, 7) != 0, w, $urandom(), 1'($urandom_range(0, 1)));
        end
        step(0, 32'h0, 32'h0, 0);
        step(0, 32'h0, 32'h0, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule